// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block tells a DRAM memory controller when a refresh is due. An interval timer runs freely from reset and expires once every `INTERVAL` clock cycles. Each expiry adds one refresh to an owed count. The request output is high while anything is owed. The controller accepts one refresh at a time through a valid/ready handshake. The default interval is 15.6 us divided by the clock period, rounded down. At that spacing, 1,024 refreshes take less than 16 ms, which meets the retention requirement of a 1,024-row part.

A mode input chooses the refresh style the controller will issue. In CAS-before-RAS mode the DRAM's own counter picks the row, so `row_addr` is don't-care and the block's row counter stays where it is. In RAS-only mode the controller drives `row_addr` onto the address pins, strobes RAS alone and leaves CAS high, so the cycle refreshes that row without a data access. Each accepted refresh in this mode moves the row counter on by one.

The handshake follows the usual stream rules. `ref_valid` stays high until a transfer happens. A transfer happens in any cycle where `ref_valid` and `ref_ready` are both high. The controller may hold `ref_ready` low for as long as it needs, and the owed count records the refreshes that are falling behind in the meantime.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset and right after it, `ref_valid` is 0, `row_addr` is 0 and the owed count is 0.
- R2: The timer expires on the `INTERVAL`-th rising clock edge after reset is released and then on every `INTERVAL`-th edge after that. Each expiry adds one refresh to the owed count.
- R3: Once `ref_valid` is 1, it stays 1 until an edge where `ref_ready` is 1.
- R4: `ref_valid` is 1 exactly when the owed count is nonzero. A transfer removes one from the count. A transfer and an expiry on the same edge leave the count unchanged.
- R5: The owed count saturates at `PEND_MAX` (8). An expiry that arrives while the count is at 8 and no transfer happens is lost.
- R6: When `ras_only_mode` is 1 during a transfer, `row_addr` increases by one on that edge, and 1023 wraps to 0. Without a transfer, `row_addr` does not change.
- R7: When `ras_only_mode` is 0 during a transfer, `row_addr` keeps its value.
- R8: Starting from reset, 1,024 consecutive RAS-only transfers present every row from 0 to 1023 exactly once, and `row_addr` then reads 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_only_mode | input | 1 | 1 = RAS-only refresh, 0 = CAS-before-RAS refresh |
| ref_valid | output | 1 | A refresh is owed |
| ref_ready | input | 1 | The controller accepts the offered refresh |
| row_addr | output | ROW_BITS (10) | Row for a RAS-only refresh |

## Verification
The bench uses `INTERVAL` = 4 and keeps the full 10-bit row counter and the owed limit of 8. With a four-cycle interval, a complete lap of all 1,024 rows fits in a few thousand cycles, so R8 is checked exhaustively, including the wrap from 1023 to 0. The short interval also lets the owed count be driven into saturation and drained again within a few dozen cycles. Ready patterns that are always on, always off and periodic make expiries land on the same edges as transfers. The bench compares every cycle against a model built from edge counts.

// File: rtl/refresh_pkg.sv
`timescale 1ns/1ps
package refresh_pkg;
  typedef enum logic {
    REF_CBR      = 1'b0,
    REF_RAS_ONLY = 1'b1
  } ref_mode_e;

  // cycles per refresh slot for a given clock period in picoseconds
  function automatic int unsigned slot_cycles(input int unsigned clk_ps);
    return 15_600_000 / clk_ps;
  endfunction
endpackage

// File: rtl/refresh_interval_timer.sv
`timescale 1ns/1ps
module refresh_interval_timer #(
  parameter int unsigned INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  output logic expire
);
  localparam int unsigned CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

  logic [CW-1:0] remain;

  assign expire = (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      remain <= RELOAD;
    else if (expire) remain <= RELOAD;
    else             remain <= remain - 1'b1;
  end
endmodule

// File: rtl/refresh_owed_counter.sv
`timescale 1ns/1ps
module refresh_owed_counter #(
  parameter int unsigned PEND_MAX = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          expire,
  input  logic                          take,
  output logic [$clog2(PEND_MAX+1)-1:0] owed,
  output logic                          pending
);
  localparam int unsigned OW = $clog2(PEND_MAX + 1);
  localparam logic [OW-1:0] CAP = OW'(PEND_MAX);

  assign pending = (owed != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed <= '0;
    end else begin
      unique case ({expire, take})
        2'b10:   if (owed != CAP) owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end
endmodule

// File: rtl/refresh_row_counter.sv
`timescale 1ns/1ps
module refresh_row_counter #(
  parameter int unsigned ROW_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  output logic [ROW_BITS-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row <= '0;
    else if (step) row <= row + 1'b1;
  end
endmodule

// File: rtl/dram_refresh_sched.sv
`timescale 1ns/1ps
module dram_refresh_sched #(
  parameter int unsigned CLK_PS   = 20_000,
  parameter int unsigned INTERVAL = refresh_pkg::slot_cycles(CLK_PS),
  parameter int unsigned ROW_BITS = 10,
  parameter int unsigned PEND_MAX = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_only_mode,
  output logic                ref_valid,
  input  logic                ref_ready,
  output logic [ROW_BITS-1:0] row_addr
);
  import refresh_pkg::*;

  localparam int unsigned OW = $clog2(PEND_MAX + 1);

  ref_mode_e       mode;
  logic            expire;
  logic            take;
  logic [OW-1:0]   owed_cnt;

  assign mode = ref_mode_e'(ras_only_mode);
  assign take = ref_valid && ref_ready;

  refresh_interval_timer #(.INTERVAL(INTERVAL)) timer_i (
    .clk(clk), .rst_n(rst_n), .expire(expire)
  );

  refresh_owed_counter #(.PEND_MAX(PEND_MAX)) owed_i (
    .clk(clk), .rst_n(rst_n), .expire(expire), .take(take),
    .owed(owed_cnt), .pending(ref_valid)
  );

  refresh_row_counter #(.ROW_BITS(ROW_BITS)) row_i (
    .clk(clk), .rst_n(rst_n), .step(take && (mode == REF_RAS_ONLY)),
    .row(row_addr)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
`timescale 1ns/1ps
module refresh_sched_chk #(
  parameter int unsigned INTERVAL = 780,
  parameter int unsigned ROW_BITS = 10,
  parameter int unsigned PEND_MAX = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          ras_only_mode,
  input logic                          ref_valid,
  input logic                          ref_ready,
  input logic [ROW_BITS-1:0]           row_addr,
  input logic                          expire,
  input logic [$clog2(PEND_MAX+1)-1:0] owed_cnt
);
  localparam int unsigned GW = $clog2(INTERVAL + 1) + 1;
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap <= '0;
    else if (expire) gap <= '0;
    else             gap <= gap + 1'b1;
  end

  a_r2_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (gap == GW'(INTERVAL - 1)));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && !ref_ready) |=> ref_valid);

  a_r4_rise_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_valid) |-> $past(expire));

  a_r5_cap: assert property (@(posedge clk) disable iff (!rst_n)
    owed_cnt <= ($clog2(PEND_MAX+1))'(PEND_MAX));

  a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ref_ready && ras_only_mode) |=>
      (row_addr == $past(row_addr) + 1'b1));

  a_r6_idle_row: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_valid && ref_ready) |=> $stable(row_addr));

  a_r7_cbr_row: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ref_ready && !ras_only_mode) |=> $stable(row_addr));
endmodule

bind dram_refresh_sched refresh_sched_chk #(
  .INTERVAL(INTERVAL), .ROW_BITS(ROW_BITS), .PEND_MAX(PEND_MAX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ras_only_mode(ras_only_mode),
  .ref_valid(ref_valid), .ref_ready(ref_ready), .row_addr(row_addr),
  .expire(expire), .owed_cnt(owed_cnt)
);

// File: tb/dram_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb_top;
  localparam int INTERVAL = 4;
  localparam int ROW_BITS = 10;
  localparam int PEND_MAX = 8;
  localparam int ROWS     = 1 << ROW_BITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_only_mode = 1'b0;
  logic ref_ready = 1'b0;
  logic ref_valid;
  logic [ROW_BITS-1:0] row_addr;

  always #10 clk = ~clk;

  dram_refresh_sched #(
    .INTERVAL(INTERVAL), .ROW_BITS(ROW_BITS), .PEND_MAX(PEND_MAX)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_only_mode(ras_only_mode),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .row_addr(row_addr)
  );

  int checks = 0;
  int errors = 0;
  int edges = 0;
  int exp_owed = 0;
  int exp_row = 0;
  int accepted = 0;
  bit record = 1'b0;
  int seen [ROWS];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    edges = 0; exp_owed = 0; exp_row = 0;
    repeat (3) @(negedge clk);
    chk(ref_valid == 1'b0, "R1 valid", int'(ref_valid), 0);
    chk(row_addr == '0, "R1 row", int'(row_addr), 0);
    rst_n = 1'b1;
  endtask

  // called at a negedge: drive, advance model, wait one edge, compare
  task automatic step(input bit rdy, input bit ras, input string req);
    bit acc, tick;
    ref_ready = rdy;
    ras_only_mode = ras;
    acc = (exp_owed != 0) && rdy;
    if (acc && ras && record) seen[int'(row_addr)]++;
    if (acc && ras) accepted++;
    edges++;
    tick = (edges % INTERVAL) == 0;
    if (tick && !acc && exp_owed < PEND_MAX) exp_owed++;
    else if (acc && !tick) exp_owed--;
    if (acc && ras) exp_row = (exp_row + 1) % ROWS;
    @(posedge clk);
    @(negedge clk);
    chk(ref_valid == (exp_owed != 0), {req, " valid"}, int'(ref_valid), int'(exp_owed != 0));
    chk(int'(row_addr) == exp_row, {req, " row"}, int'(row_addr), exp_row);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R2: first request appears on edge INTERVAL
    for (int i = 0; i < INTERVAL; i++) step(1'b0, 1'b0, "R2");
    chk(ref_valid == 1'b1, "R2 first request", int'(ref_valid), 1);
    // R3: held without ready
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, "R3");
    // R5: run far past saturation
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0, "R5");
    chk(exp_owed == PEND_MAX, "R5 model cap", exp_owed, PEND_MAX);
    // R5/R7: drain in CBR mode, row must not move
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0, "R7");
    chk(row_addr == '0, "R7 row after CBR drain", int'(row_addr), 0);
    // R4: periodic ready so transfers coincide with expiries
    for (int i = 0; i < 60; i++) step((i % 3) != 0, 1'b0, "R4");
    for (int i = 0; i < 60; i++) step((i % 4) == 3, 1'b1, "R4");
    chk(exp_row > 0, "R6 rows advanced", exp_row, 1);
    // R1: mid-run reset, then R8 full sweep
    do_reset();
    for (int r = 0; r < ROWS; r++) seen[r] = 0;
    accepted = 0;
    record = 1'b1;
    while (accepted < ROWS) step(1'b1, 1'b1, "R6");
    record = 1'b0;
    for (int r = 0; r < ROWS; r++)
      chk(seen[r] == 1, "R8 row visits", seen[r], 1);
    chk(row_addr == '0, "R8 wrap to 0", int'(row_addr), 0);
    // R7 after sweep: CBR transfers leave row at 0
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, "R7");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule